// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM with a 16-bit data path. The host asks for one word at a time. It gives a write flag, a word address, write data and a two-bit lane mask. The controller turns each request into a timed sequence on the memory pins. These pins are an active-low primary select, an active-high secondary select, the write strobe, the output strobe, and one active-low enable per byte lane. The data bus is split into an outgoing word, a drive enable and an incoming word, so that a tri-state pad outside the block can join them.

Each memory timing minimum is given as a nanosecond parameter. It is turned into a whole number of clock cycles by rounding up, and never falls below one cycle. A single down-counter times every phase of the sequence: setup, strobe, hold and bus turnaround. The host sees a ready level, a one-cycle acknowledge and the returned word.

Top module: `sram_async_ctl`

## Requirements
- R1: While in reset, and in every idle cycle afterwards, host_ready is high, host_ack is low, the memory is deselected (mem_ce1_n high, mem_ce2 low), mem_we_n and mem_oe_n are high, and mem_dout_en is low.
- R2: A write holds mem_we_n low for at least T_WP_NS. The write data is driven, unchanged, with mem_dout_en high, for at least T_SD_NS before mem_we_n rises.
- R3: Between the rise of the selects and their fall, a write occupies the memory for at least T_WC_NS.
- R4: Mask bit 0 enables the low lane (mem_lb_n low, data bits 7:0). Mask bit 1 enables the high lane (mem_ub_n low, bits 15:8). A write leaves a disabled lane of the addressed word unchanged.
- R5: A read drives mem_oe_n low with mem_we_n high. It samples mem_din no earlier than T_AA_NS after the address and selects change and T_DOE_NS after mem_oe_n falls, and it returns the stored word.
- R6: On host_rdata, any lane whose mask bit is 0 reads as zero.
- R7: mem_oe_n is high in every cycle in which mem_we_n is low.
- R8: mem_dout_en is never high while the memory drives the bus, or within T_HZ_NS after mem_oe_n rises.
- R9: A request is taken only when host_ready is high. host_ready stays low from acceptance until the operation ends. host_ack lasts exactly one cycle for each request.
- R10: The write acknowledge comes 1 + max(ceil(T_WP_NS), ceil(T_SD_NS)) + max(1, ceil(T_WC_NS) - 1 - strobe) cycles after acceptance. The read acknowledge comes max(ceil(T_AA_NS), ceil(T_DOE_NS)) cycles after acceptance. Every ceiling is in clock periods and is at least 1.
- R11: With a mask of 00, both lane enables stay high, so the memory is not selected. A write then changes nothing, and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request valid |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Word address |
| host_wdata | input | 16 | Write word |
| host_bmask | input | 2 | Lane mask, bit 0 = low byte |
| host_ready | output | 1 | Idle, request will be taken |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read word, valid with host_ack |
| mem_addr | output | 19 | Memory address |
| mem_ce1_n | output | 1 | Primary select, active low |
| mem_ce2 | output | 1 | Secondary select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_ub_n | output | 1 | High lane enable, active low |
| mem_lb_n | output | 1 | Low lane enable, active low |
| mem_dout | output | 16 | Outgoing data word |
| mem_dout_en | output | 1 | Drive enable for the pad |
| mem_din | input | 16 | Incoming data word |

## Verification
The bench builds the block with its defaults: a 10 ns clock, a 35 ns strobe, 25 ns data setup, 45 ns cycle and access, 22 ns output access and 18 ns turn-off. These values make the write strobe depend on the pulse-width limit rather than the data-setup limit. The hold phase falls to its one-cycle floor, and the read wait depends on the address access time rather than the output access time. With them the acknowledge latencies are six cycles for a write and five for a read. The memory model returns an inverted word until the access times have passed, so a read sampled even one cycle early is caught.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_TURN
    } phase_e;

    // Internal active-high view of the memory control pins
    typedef struct packed {
        logic sel;     // both chip selects active
        logic wr_stb;  // write strobe
        logic rd_stb;  // output strobe
        logic lanes;   // byte lanes enabled (qualified by mask)
        logic drive;   // controller drives the data pins
    } strobe_t;

    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned cmax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t strobes_for(input phase_e ph, input logic is_wr);
        strobe_t s;
        s = '0;
        case (ph)
            PH_SETUP: begin
                s.sel   = 1'b1;
                s.lanes = 1'b1;
                s.drive = 1'b1;
            end
            PH_STROBE: begin
                s.sel   = 1'b1;
                s.lanes = 1'b1;
                if (is_wr) begin
                    s.wr_stb = 1'b1;
                    s.drive  = 1'b1;
                end else begin
                    s.rd_stb = 1'b1;
                end
            end
            PH_HOLD: begin
                s.sel   = 1'b1;
                s.lanes = 1'b1;
            end
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // R10: an expired count stays expired until the next phase loads it
    count_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> done);

endmodule

// File: rtl/sram_lane_ctl.sv
module sram_lane_ctl #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic [LANES-1:0]        mask,
    input  logic                    lanes_on,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES-1:0]        be,
    output logic [LANES*LANE_W-1:0] rd_word
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign be[i] = lanes_on & mask[i];
        assign rd_word[i*LANE_W +: LANE_W] = mask[i] ? din[i*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 19,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CLK_NS    = 10,
    parameter int unsigned T_WP_NS   = 35,
    parameter int unsigned T_WC_NS   = 45,
    parameter int unsigned T_SD_NS   = 25,
    parameter int unsigned T_AA_NS   = 45,
    parameter int unsigned T_DOE_NS  = 22,
    parameter int unsigned T_HZ_NS   = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [1:0]        host_bmask,
    output logic              host_ready,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);

    localparam int unsigned LANE_W  = DATA_W / 2;
    localparam int unsigned WP_C    = ns2cyc(T_WP_NS, CLK_NS);
    localparam int unsigned SD_C    = ns2cyc(T_SD_NS, CLK_NS);
    localparam int unsigned WC_C    = ns2cyc(T_WC_NS, CLK_NS);
    localparam int unsigned AA_C    = ns2cyc(T_AA_NS, CLK_NS);
    localparam int unsigned DOE_C   = ns2cyc(T_DOE_NS, CLK_NS);
    localparam int unsigned HZ_C    = ns2cyc(T_HZ_NS, CLK_NS);
    localparam int unsigned SETUP_C = 1;
    localparam int unsigned WSTR_C  = cmax(WP_C, SD_C);
    localparam int unsigned WHOLD_C = (WC_C > SETUP_C + WSTR_C) ? (WC_C - SETUP_C - WSTR_C) : 1;
    localparam int unsigned RD_C    = cmax(AA_C, DOE_C);
    localparam int unsigned TURN_C  = HZ_C;
    localparam int unsigned LONG_C  = cmax(cmax(WSTR_C, WHOLD_C), cmax(RD_C, TURN_C));
    localparam int unsigned CW      = $clog2(LONG_C + 1);

    phase_e              ph_q, ph_d;
    logic                is_wr_q, wr_d;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [1:0]          mask_q;
    strobe_t             pins_q;
    logic                ack_q;
    logic [DATA_W-1:0]   rdata_q;
    logic                accept, fin_rd, fin_wr;
    logic                ld;
    logic [CW-1:0]       ld_val;
    logic                t_done;
    logic [1:0]          be;
    logic [DATA_W-1:0]   rd_word;

    assign accept = (ph_q == PH_IDLE) && host_req;
    assign wr_d   = accept ? host_we : is_wr_q;

    always_comb begin
        ph_d   = ph_q;
        ld     = 1'b0;
        ld_val = '0;
        fin_rd = 1'b0;
        fin_wr = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (host_req) begin
                    ld = 1'b1;
                    if (host_we) begin
                        ph_d   = PH_SETUP;
                        ld_val = CW'(SETUP_C - 1);
                    end else begin
                        ph_d   = PH_STROBE;
                        ld_val = CW'(RD_C - 1);
                    end
                end
            end
            PH_SETUP: begin
                if (t_done) begin
                    ph_d   = PH_STROBE;
                    ld     = 1'b1;
                    ld_val = CW'(WSTR_C - 1);
                end
            end
            PH_STROBE: begin
                if (t_done) begin
                    ld = 1'b1;
                    if (is_wr_q) begin
                        ph_d   = PH_HOLD;
                        ld_val = CW'(WHOLD_C - 1);
                    end else begin
                        ph_d   = PH_TURN;
                        ld_val = CW'(TURN_C - 1);
                        fin_rd = 1'b1;
                    end
                end
            end
            PH_HOLD: begin
                if (t_done) begin
                    ph_d   = PH_IDLE;
                    fin_wr = 1'b1;
                end
            end
            PH_TURN: begin
                if (t_done) ph_d = PH_IDLE;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    sram_phase_timer #(.CW(CW)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .done     (t_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            is_wr_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            pins_q  <= '0;
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ph_q    <= ph_d;
            is_wr_q <= wr_d;
            pins_q  <= strobes_for(ph_d, wr_d);
            ack_q   <= fin_rd | fin_wr;
            if (accept) begin
                addr_q  <= host_addr;
                wdata_q <= host_wdata;
                mask_q  <= host_bmask;
            end
            if (fin_rd) rdata_q <= rd_word;
        end
    end

    sram_lane_ctl #(.LANES(2), .LANE_W(LANE_W)) i_lanes (
        .mask     (mask_q),
        .lanes_on (pins_q.lanes),
        .din      (mem_din),
        .be       (be),
        .rd_word  (rd_word)
    );

    assign host_ready  = (ph_q == PH_IDLE);
    assign host_ack    = ack_q;
    assign host_rdata  = rdata_q;
    assign mem_addr    = addr_q;
    assign mem_ce1_n   = ~pins_q.sel;
    assign mem_ce2     = pins_q.sel;
    assign mem_we_n    = ~pins_q.wr_stb;
    assign mem_oe_n    = ~pins_q.rd_stb;
    assign mem_lb_n    = ~be[0];
    assign mem_ub_n    = ~be[1];
    assign mem_dout    = wdata_q;
    assign mem_dout_en = pins_q.drive;

    // R7
    oe_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    // R8
    dout_turn_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dout_en |-> (mem_oe_n && $past(mem_oe_n)));

    // R2
    data_thru_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> $past(mem_dout_en));

    // R9
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    // R9
    idle_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (host_ready && !host_req) |=> host_ready);

    // R1
    idle_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> (mem_ce1_n && !mem_ce2 && !mem_dout_en));

endmodule

// File: tb/test_sram_async_ctl.sv
module test_sram_async_ctl;

    localparam int CLK = 10;
    localparam int TWP = 35, TWC = 45, TSD = 25, TAA = 45, TDOE = 22, THZ = 18;

    function automatic int cdiv(input int ns);
        int c;
        c = (ns + CLK - 1) / CLK;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int STR   = (cdiv(TWP) > cdiv(TSD)) ? cdiv(TWP) : cdiv(TSD);
    localparam int W_LAT = 1 + STR + ((cdiv(TWC) > 1 + STR) ? cdiv(TWC) - 1 - STR : 1);
    localparam int R_LAT = (cdiv(TAA) > cdiv(TDOE)) ? cdiv(TAA) : cdiv(TDOE);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [18:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_bmask = '0;
    logic        host_ready, host_ack;
    logic [15:0] host_rdata;
    logic [18:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n;
    logic [15:0] mem_dout;
    logic        mem_dout_en;
    logic [15:0] mem_din = '0;

    sram_async_ctl i_sram_async_ctl (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_bmask(host_bmask),
        .host_ready(host_ready), .host_ack(host_ack), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n),
        .mem_lb_n(mem_lb_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] init_word(input int a);
        return a[15:0] ^ 16'hA5A5;
    endfunction

    // ---------------- memory model ----------------
    logic [15:0] mdl [int];
    logic [15:0] ref_mem [int];

    function automatic logic [15:0] mdl_rd(input int a);
        return mdl.exists(a) ? mdl[a] : init_word(a);
    endfunction

    logic [18:0] last_addr = '0;
    int addr_age = 0, oe_age = 0, we_cnt = 0, dat_age = 0, sel_age = 0, since_drv = 100;
    logic prev_ovl = 0, prev_sel = 0, sel_wrote = 0;
    logic [15:0] prev_dout = '0;
    logic [1:0]  prev_lanes = '0;
    logic [18:0] prev_addr = '0;
    bit contention = 0, oe_we_both = 0;

    always @(negedge clk) begin
        logic sel, ovl, drv;
        logic [15:0] w;
        sel = !mem_ce1_n && mem_ce2 && (!mem_ub_n || !mem_lb_n);
        ovl = sel && !mem_we_n;
        drv = sel && !mem_oe_n && mem_we_n;
        addr_age = (mem_addr != last_addr) ? 1 : addr_age + 1;
        last_addr = mem_addr;
        oe_age = drv ? oe_age + 1 : 0;
        if (addr_age > 1000) addr_age = 1000;
        if (mem_dout_en) dat_age = (mem_dout == prev_dout && dat_age > 0) ? dat_age + 1 : 1;
        else dat_age = 0;
        // R8: bus overlap with memory drive or its turn-off window
        if (mem_dout_en && (drv || (since_drv - 1) * CLK < THZ)) contention = 1;
        since_drv = drv ? 0 : ((since_drv < 100) ? since_drv + 1 : 100);
        // R7
        if (!mem_we_n && !mem_oe_n) oe_we_both = 1;
        if (ovl) we_cnt++;
        if (prev_ovl && !ovl) begin
            chk(we_cnt * CLK >= TWP, "R2 strobe width", we_cnt * CLK, TWP);
            chk(dat_setup_ok(), "R2 data setup", prev_dat_age * CLK, TSD);
            w = mdl_rd(int'(prev_addr));
            if (prev_lanes[0]) w[7:0]  = prev_dout[7:0];
            if (prev_lanes[1]) w[15:8] = prev_dout[15:8];
            mdl[int'(prev_addr)] = w;
            we_cnt = 0;
            sel_wrote = 1;
        end
        if (sel) sel_age++;
        if (prev_sel && !sel) begin
            if (sel_wrote) chk(sel_age * CLK >= TWC, "R3 write cycle", sel_age * CLK, TWC);
            sel_age = 0;
            sel_wrote = 0;
        end
        w = mdl_rd(int'(mem_addr));
        if (drv && addr_age * CLK >= TAA && oe_age * CLK >= TDOE) begin
            mem_din = w;
            if (mem_lb_n) mem_din[7:0]  = ~w[7:0];
            if (mem_ub_n) mem_din[15:8] = ~w[15:8];
        end else begin
            mem_din = ~w;
        end
        prev_dat_age = dat_age;
        prev_ovl = ovl;
        prev_sel = sel;
        prev_dout = mem_dout;
        prev_lanes = {!mem_ub_n, !mem_lb_n};
        prev_addr = mem_addr;
    end

    int prev_dat_age = 0;
    function automatic bit dat_setup_ok();
        return prev_dat_age * CLK >= TSD;
    endfunction

    // ---------------- scoreboard ----------------
    typedef struct {
        logic        rd;
        logic [15:0] d;
        logic [1:0]  m;
        int          acc;
        int          lat;
    } exp_t;
    exp_t q[$];

    always @(negedge clk) begin
        if (!rst && host_ack) begin
            if (q.size() == 0) begin
                chk(0, "R9 unexpected ack", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(cyc - e.acc == e.lat, "R10 ack latency", cyc - e.acc, e.lat);
                if (e.rd) begin
                    if (e.m == 2'b00)      chk(host_rdata == e.d, "R11 read data", host_rdata, e.d);
                    else if (e.m != 2'b11) chk(host_rdata == e.d, "R6 read data", host_rdata, e.d);
                    else                   chk(host_rdata == e.d, "R5 read data", host_rdata, e.d);
                end
            end
        end
    end

    task automatic do_op(input logic w, input int a, input logic [15:0] d, input logic [1:0] m);
        exp_t e;
        logic [15:0] r;
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_we = w; host_addr = a[18:0]; host_wdata = d; host_bmask = m;
        r = ref_mem.exists(a) ? ref_mem[a] : init_word(a);
        if (w) begin
            if (m[0]) r[7:0]  = d[7:0];
            if (m[1]) r[15:8] = d[15:8];
            ref_mem[a] = r;
        end
        @(negedge clk);
        host_req = 1'b0;
        e.rd  = !w;
        e.d   = {m[1] ? r[15:8] : 8'h00, m[0] ? r[7:0] : 8'h00};
        e.m   = m;
        e.acc = cyc;
        e.lat = w ? W_LAT : R_LAT;
        q.push_back(e);
        chk(!host_ready, "R9 busy after accept", host_ready, 0);
        chk(mem_lb_n == !m[0] && mem_ub_n == !m[1], m == 2'b00 ? "R11 lanes off" : "R4 lane enables",
            {mem_ub_n, mem_lb_n}, {!m[1], !m[0]});
        if (!w) chk(!mem_oe_n && mem_we_n, "R5 read strobes", {mem_oe_n, mem_we_n}, 2'b01);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dout_en, "R1 pins in reset",
            {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dout_en}, 5'b10110);
        rst = 1'b0;
        @(negedge clk);
        chk(host_ready == 1'b1, "R1 ready", host_ready, 1);
        chk(host_ack == 1'b0, "R1 ack", host_ack, 0);
        chk(mem_ce1_n && !mem_ce2, "R1 deselected", {mem_ce1_n, mem_ce2}, 2'b10);
        chk(mem_we_n && mem_oe_n && !mem_dout_en, "R1 strobes idle",
            {mem_we_n, mem_oe_n, mem_dout_en}, 3'b110);

        // R4 R5 full word
        do_op(1, 'h10, 16'h1234, 2'b11);
        do_op(0, 'h10, 16'h0, 2'b11);
        // R4 single lanes
        do_op(1, 'h10, 16'hABCD, 2'b01);
        do_op(0, 'h10, 16'h0, 2'b11);
        do_op(1, 'h10, 16'h5678, 2'b10);
        do_op(0, 'h10, 16'h0, 2'b11);
        // R6 partial reads
        do_op(0, 'h10, 16'h0, 2'b10);
        do_op(0, 'h10, 16'h0, 2'b01);
        // R11 empty mask
        do_op(1, 'h10, 16'hFFFF, 2'b00);
        do_op(0, 'h10, 16'h0, 2'b00);
        do_op(0, 'h10, 16'h0, 2'b11);
        // address extremes and unwritten location
        do_op(1, 'h7FFFF, 16'hBEEF, 2'b11);
        do_op(1, 'h0, 16'hC0DE, 2'b11);
        do_op(0, 'h7FFFF, 16'h0, 2'b11);
        do_op(0, 'h0, 16'h0, 2'b11);
        do_op(0, 'h12345, 16'h0, 2'b11);
        // mixed traffic: write-to-read and read-to-write turnarounds (R8)
        seed = 7;
        for (int i = 0; i < 40; i++) begin
            seed = seed * 1103515245 + 12345;
            do_op(seed[3], 32'(seed[20:16]) + 'h200, seed[31:16], seed[5:4]);
        end
        for (int i = 0; i < 32; i++) do_op(0, 'h200 + i, 16'h0, 2'b11);

        while (q.size() != 0 || !host_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(!contention, "R8 bus contention", contention, 0);
        chk(!oe_we_both, "R7 output strobe during write", oe_we_both, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule